// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Transceiver

This block is a full-duplex asynchronous serial core that carries nine data bits per character. On a shared multidrop line the ninth bit marks a character as a station address (1) or as payload (0). With the attention control set, the receiver ignores all payload characters and wakes only on an address character. When it accepts one, it clears the attention control itself, so the payload that follows is received until software sets the control again.

Software uses a small register port with three addresses: data, control and status. A 16x oversampling tick paces both directions. The core also offers three extra functions. An internal loopback routes the transmit shifter into the receiver for self-test. A break control holds the line low. A low-power reinitialisation pulse returns the transmit and receive machines to idle and leaves the software-written settings untouched.

Top module: `usart9_core`

## Requirements
- R1: A transmitted character is a 0 start bit, nine data bits least significant first, then one stop bit (control bit 1 = 0) or two stop bits (control bit 1 = 1) at level 1. The transmit line idles at 1 from reset.
- R2: The ninth transmitted bit is control bit 0, taken at the moment the transmitter picks up the buffered byte written to address 0.
- R3: Status bit 0 (transmit buffer empty) reads 1 after reset. A write to address 0 clears it. It sets again when the transmitter takes the byte, so a second byte can wait in the buffer while a character is on the line.
- R4: A received character is detected on a falling edge, confirmed at the middle of the start bit (8th tick) and sampled at each following mid-bit. Address 0 reads its low eight bits, status bit 4 reads its ninth bit, and status bit 1 (receive full) sets.
- R5: With control bit 2 (attention) at 1, a character whose ninth bit is 0 is discarded: receive full, the buffer and all flags are unchanged.
- R6: With attention at 1, a character whose ninth bit is 1 is accepted as in R4, and control bit 2 reads back 0 afterwards.
- R7: A 0 sampled at the first stop bit of an accepted character sets status bit 2 (framing error).
- R8: A character that completes while receive full is set sets status bit 3 (overrun). The character is discarded and the buffer keeps the older one.
- R9: Any write to address 2 clears status bits 2 and 3.
- R10: When control bits 5 and 4 are both 1, the receiver takes its input from the transmit shifter and the rxd pin has no effect.
- R11: While control bit 3 (break) is 1, txd is 0. It follows the transmitter again once the bit is cleared.
- R12: A pulse on lp_reinit sets transmit buffer empty, clears receive full and both error flags, returns txd to 1 with no further character sent, and keeps the control register and the received data.
- R13: rx_irq equals receive full AND control bit 6. A read of address 0 with reg_re at 1 clears receive full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect on address 0 only) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| rx_irq | output | 1 | Receive interrupt request |
| lp_reinit | input | 1 | Low-power entry pulse that reinitialises the core |

## Verification
On every cycle the embedded properties check the following. The transmit shifter marks 1 when idle and drives a 0 start bit right after it takes a byte. A taken byte frees the buffer. Completion is a single-cycle pulse. A discarded payload character leaves the receive buffer and the full flag unchanged. An accepted address character drops attention. An overrun keeps the old buffer. The reinitialisation pulse leaves the status in its stated state. Only the bench scenarios can show the rest: whole-frame bit order and stop-bit spacing on txd, framing errors from a bad stop bit, the loopback path with rxd held low, and a long random mix of address, payload and bad-stop characters against a reference model.

// File: rtl/usart9_pkg.sv
`timescale 1ns/1ps
package usart9_pkg;
  localparam int DW = 9;
  localparam int RW = 8;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam int C_TX8  = 0;
  localparam int C_TWO  = 1;
  localparam int C_ATTN = 2;
  localparam int C_BRK  = 3;
  localparam int C_CHLO = 4;
  localparam int C_CHHI = 5;
  localparam int C_RXIE = 6;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/usart9_tx.sv
`timescale 1ns/1ps
module usart9_tx #(
  parameter int DW  = 9,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick,
  input  logic          reinit,
  input  logic          req,
  input  logic [DW-1:0] data,
  input  logic          two_stop,
  output logic          line,
  output logic          taken
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] left_q, left_d;
  logic          busy_q, busy_d;

  assign taken = req && !busy_q && !reinit;
  assign line  = sh_q[0];

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    busy_d = busy_q;
    if (reinit) begin
      sh_d   = '1;
      cnt_d  = '0;
      left_d = '0;
      busy_d = 1'b0;
    end else if (taken) begin
      sh_d   = {2'b11, data, 1'b0};
      cnt_d  = '0;
      left_d = two_stop ? LW'(FW) : LW'(FW - 1);
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (cnt_q == CW'(OVS - 1)) begin
        cnt_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - LW'(1);
        if (left_q == LW'(1)) busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  // R1: an idle shifter presents the mark level
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |-> line);
  // R1: a taken byte starts with a 0 start bit on the next cycle
  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    taken |=> !line);
endmodule

// File: rtl/usart9_rx.sv
`timescale 1ns/1ps
module usart9_rx
  import usart9_pkg::*;
#(
  parameter int DW  = 9,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick,
  input  logic          reinit,
  input  logic          line,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          stop_ok
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          prev_q, prev_d;
  logic          done_q, done_d;
  logic          stop_q, stop_d;

  assign done    = done_q;
  assign data    = sh_q;
  assign stop_ok = stop_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    prev_d = prev_q;
    stop_d = stop_q;
    done_d = 1'b0;
    if (reinit) begin
      st_d   = RX_IDLE;
      cnt_d  = '0;
      idx_d  = '0;
      prev_d = 1'b1;
    end else if (tick) begin
      prev_d = line;
      case (st_q)
        RX_IDLE: begin
          if (prev_q && !line) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            st_d  = line ? RX_IDLE : RX_DATA;
            cnt_d = '0;
            idx_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DW-1:1]};
            if (idx_q == IW'(DW - 1)) st_d = RX_STOP;
            else idx_d = idx_q + IW'(1);
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d  = '0;
            done_d = 1'b1;
            stop_d = line;
            st_d   = RX_IDLE;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/usart9_core.sv
`timescale 1ns/1ps
module usart9_core
  import usart9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          rx_irq,
  input  logic          lp_reinit
);
  logic rs_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ni, rs_meta} <= 2'b00;
    else        {rst_ni, rs_meta} <= {rs_meta, 1'b1};
  end

  logic rxd_m, rxd_s;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) {rxd_s, rxd_m} <= 2'b11;
    else         {rxd_s, rxd_m} <= {rxd_m, rxd};
  end

  logic [RW-1:0] ctrl_q, ctrl_d, txbuf_q, txbuf_d;
  logic [DW-1:0] rxbuf_q, rxbuf_d;
  logic tx_empty_q, tx_empty_d, rx_full_q, rx_full_d;
  logic fe_q, fe_d, ovr_q, ovr_d;

  logic tx_line, tx_taken, rx_done, rx_stop_ok, rx_line, loopback;
  logic [DW-1:0] rx_data;

  assign loopback = ctrl_q[C_CHHI] && ctrl_q[C_CHLO];
  assign rx_line  = loopback ? tx_line : rxd_s;

  usart9_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_ni(rst_ni), .tick(baud_tick), .reinit(lp_reinit),
    .req(!tx_empty_q), .data({ctrl_q[C_TX8], txbuf_q}),
    .two_stop(ctrl_q[C_TWO]), .line(tx_line), .taken(tx_taken));

  usart9_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_ni(rst_ni), .tick(baud_tick), .reinit(lp_reinit),
    .line(rx_line), .done(rx_done), .data(rx_data), .stop_ok(rx_stop_ok));

  logic wr_data, wr_ctrl, wr_stat, rd_data, accept;
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign rd_data = reg_re && (reg_addr == A_DATA);
  assign accept  = rx_done && !lp_reinit && !(ctrl_q[C_ATTN] && !rx_data[DW-1]);

  always_comb begin
    ctrl_d     = ctrl_q;
    txbuf_d    = txbuf_q;
    rxbuf_d    = rxbuf_q;
    tx_empty_d = tx_empty_q;
    rx_full_d  = rx_full_q;
    fe_d       = fe_q;
    ovr_d      = ovr_q;
    if (wr_ctrl) ctrl_d = reg_wdata;
    if (wr_data) txbuf_d = reg_wdata;
    if (lp_reinit) begin
      tx_empty_d = 1'b1;
      rx_full_d  = 1'b0;
      fe_d       = 1'b0;
      ovr_d      = 1'b0;
    end else begin
      if (tx_taken) tx_empty_d = 1'b1;
      if (wr_data)  tx_empty_d = 1'b0;
      if (wr_stat) begin
        fe_d  = 1'b0;
        ovr_d = 1'b0;
      end
      if (rd_data) rx_full_d = 1'b0;
      if (accept) begin
        ctrl_d[C_ATTN] = 1'b0;
        if (rx_full_q && !rd_data) begin
          ovr_d = 1'b1;
        end else begin
          rxbuf_d   = rx_data;
          rx_full_d = 1'b1;
          fe_d      = fe_d | !rx_stop_ok;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      txbuf_q    <= '0;
      rxbuf_q    <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      fe_q       <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      txbuf_q    <= txbuf_d;
      rxbuf_q    <= rxbuf_d;
      tx_empty_q <= tx_empty_d;
      rx_full_q  <= rx_full_d;
      fe_q       <= fe_d;
      ovr_q      <= ovr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rxbuf_q[RW-1:0];
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {3'b000, rxbuf_q[DW-1], ovr_q, fe_q, rx_full_q, tx_empty_q};
      default: reg_rdata = '0;
    endcase
  end

  assign txd    = ctrl_q[C_BRK] ? 1'b0 : tx_line;
  assign rx_irq = rx_full_q && ctrl_q[C_RXIE];

  // R3: the transmitter taking the byte frees the buffer
  p_take_frees_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_taken && !wr_data) |=> tx_empty_q);
  // R5: a payload character under attention leaves the receive side untouched
  p_attn_drop_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_done && ctrl_q[C_ATTN] && !rx_data[DW-1] && !lp_reinit && !rd_data)
      |=> ($stable(rxbuf_q) && $stable(rx_full_q)));
  // R6: an address character under attention drops attention
  p_attn_clear_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_done && ctrl_q[C_ATTN] && rx_data[DW-1] && !lp_reinit) |=> !ctrl_q[C_ATTN]);
  // R8: overrun keeps the older character
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && rx_full_q && !rd_data) |=> (ovr_q && $stable(rxbuf_q)));
  // R12: state after the low-power reinitialisation pulse
  p_reinit_state_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    lp_reinit |=> (tx_empty_q && !rx_full_q && !fe_q && !ovr_q && (txd || ctrl_q[C_BRK])));
endmodule

// File: tb/usart9_core_tb.sv
`timescale 1ns/1ps
module usart9_core_tb;
  logic clk = 1'b0;
  logic rst_n, reg_we, reg_re, rxd, lp_reinit;
  logic baud_tick = 1'b0;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic txd, rx_irq;
  int tdiv = 0;
  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  logic m_full, m_fe, m_ovr, m_attn;
  logic [8:0] m_buf;
  logic [7:0] m_ctrl;

  usart9_core u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .rx_irq(rx_irq), .lp_reinit(lp_reinit));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic te, input logic full, input logic fe,
                                            input logic ovr, input logic [8:0] b);
    return {3'b000, b[8], ovr, fe, full, te};
  endfunction

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (baud_tick) c++;
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic clr, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = clr;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    reg_write(2'd1, v);
    m_ctrl = v;
    m_attn = v[2];
  endtask

  task automatic model_rx(input logic [8:0] d, input logic stop_ok);
    if (m_attn && !d[8]) return;
    m_attn = 1'b0;
    if (m_full) m_ovr = 1'b1;
    else begin
      m_buf  = d;
      m_full = 1'b1;
      if (!stop_ok) m_fe = 1'b1;
    end
  endtask

  task automatic chk_rx(input string tag);
    logic [7:0] v;
    reg_read(2'd2, 1'b0, v);
    check(tag, 16'(v), 16'(exp_status(1'b1, m_full, m_fe, m_ovr, m_buf)));
    reg_read(2'd0, 1'b0, v);
    check(tag, 16'(v), 16'(m_buf[7:0]));
    reg_read(2'd1, 1'b0, v);
    check(tag, 16'(v), 16'({m_ctrl[7:3], m_attn, m_ctrl[1:0]}));
    check(tag, 16'(rx_irq), 16'(m_full & m_ctrl[6]));
  endtask

  task automatic clear_all();
    logic [7:0] v;
    reg_read(2'd0, 1'b1, v);
    reg_write(2'd2, 8'h00);
    m_full = 1'b0; m_fe = 1'b0; m_ovr = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    wait_ticks(16);
    for (int k = 0; k < 9; k++) begin
      rxd = d[k];
      wait_ticks(16);
    end
    rxd = stop;
    wait_ticks(16);
    rxd = 1'b1;
    wait_ticks(6);
  endtask

  task automatic capture_tx(output logic [8:0] d, output logic stop);
    while (txd !== 1'b0) @(negedge clk);
    wait_ticks(8);
    for (int k = 0; k < 9; k++) begin
      wait_ticks(16);
      d[k] = txd;
    end
    wait_ticks(16);
    stop = txd;
  endtask

  task automatic measure_gap(output int t);
    t = 0;
    while (txd !== 1'b0) begin
      @(negedge clk);
      if (baud_tick) t++;
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [8:0] cap, d9;
    logic sb, sg;
    int gap;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    rxd = 1'b1; lp_reinit = 1'b0;
    m_full = 1'b0; m_fe = 1'b0; m_ovr = 1'b0; m_attn = 1'b0; m_buf = 9'h000; m_ctrl = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    check("R1 reset txd", 16'(txd), 16'h1);
    reg_read(2'd2, 1'b0, v);
    check("R3 reset status", 16'(v), 16'h01);
    check("R13 reset irq", 16'(rx_irq), 16'h0);

    // One stop bit, ninth bit 1, back-to-back pair
    set_ctrl(8'h41);
    reg_write(2'd0, 8'hA5);
    fork
      capture_tx(cap, sb);
      begin
        wait_ticks(20);
        reg_write(2'd0, 8'h5A);
        reg_read(2'd2, 1'b0, v);
        check("R3 pending byte", 16'(v[0]), 16'h0);
      end
    join
    check("R2 ninth bit frame", 16'(cap), 16'h1A5);
    check("R1 stop level", 16'(sb), 16'h1);
    measure_gap(gap);
    check("R1 one stop gap", 16'(gap >= 5 && gap <= 11), 16'h1);
    capture_tx(cap, sb);
    check("R2 second frame", 16'(cap), 16'h15A);
    wait_ticks(24);
    reg_read(2'd2, 1'b0, v);
    check("R3 empty after take", 16'(v[0]), 16'h1);

    // Two stop bits, ninth bit 0
    set_ctrl(8'h42);
    reg_write(2'd0, 8'h3C);
    fork
      capture_tx(cap, sb);
      begin
        wait_ticks(20);
        reg_write(2'd0, 8'hC3);
      end
    join
    check("R1 two stop frame", 16'(cap), 16'h03C);
    measure_gap(gap);
    check("R1 two stop gap", 16'(gap >= 21 && gap <= 27), 16'h1);
    capture_tx(cap, sb);
    check("R2 ninth bit 0", 16'(cap), 16'h0C3);
    wait_ticks(24);

    // Break
    set_ctrl(8'h48);
    repeat (3) @(negedge clk);
    check("R11 break low", 16'(txd), 16'h0);
    set_ctrl(8'h40);
    repeat (3) @(negedge clk);
    check("R11 break released", 16'(txd), 16'h1);

    // Receive, interrupt, read clear
    send_frame(9'h0F3, 1'b1);
    model_rx(9'h0F3, 1'b1);
    chk_rx("R4 receive");
    reg_read(2'd0, 1'b1, v);
    m_full = 1'b0;
    chk_rx("R13 read clears full");

    // Framing error, then clear
    send_frame(9'h1E1, 1'b0);
    model_rx(9'h1E1, 1'b0);
    chk_rx("R7 framing");
    reg_write(2'd2, 8'h00);
    m_fe = 1'b0; m_ovr = 1'b0;
    chk_rx("R9 error clear");

    // Overrun keeps older character
    send_frame(9'h022, 1'b1);
    model_rx(9'h022, 1'b1);
    chk_rx("R8 overrun");
    clear_all();

    // Attention: payload dropped, address accepted and attention cleared
    set_ctrl(8'h44);
    send_frame(9'h055, 1'b1);
    model_rx(9'h055, 1'b1);
    chk_rx("R5 payload dropped");
    send_frame(9'h1A2, 1'b1);
    model_rx(9'h1A2, 1'b1);
    chk_rx("R6 address accepted");
    reg_read(2'd0, 1'b1, v);
    m_full = 1'b0;
    send_frame(9'h011, 1'b1);
    model_rx(9'h011, 1'b1);
    chk_rx("R6 payload after address");
    clear_all();

    // Loopback with rxd held low
    rxd = 1'b0;
    set_ctrl(8'h71);
    reg_write(2'd0, 8'hC7);
    wait_ticks(12 * 16);
    model_rx(9'h1C7, 1'b1);
    chk_rx("R10 loopback");
    rxd = 1'b1;
    wait_ticks(4);
    set_ctrl(8'h40);
    clear_all();

    // Low-power reinitialisation mid-frame
    send_frame(9'h0B4, 1'b0);
    model_rx(9'h0B4, 1'b0);
    set_ctrl(8'h46);
    reg_write(2'd0, 8'h99);
    wait_ticks(40);
    reg_write(2'd0, 8'h66);
    wait_ticks(10);
    @(negedge clk) lp_reinit = 1'b1;
    @(negedge clk) lp_reinit = 1'b0;
    check("R12 txd released", 16'(txd), 16'h1);
    m_full = 1'b0; m_fe = 1'b0; m_ovr = 1'b0;
    chk_rx("R12 status and data");
    wait_ticks(40);
    check("R12 no further frame", 16'(txd), 16'h1);
    set_ctrl(8'h40);

    // Random mix against the model
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 3 == 0) set_ctrl(($urandom % 2 == 1) ? 8'h44 : 8'h40);
      d9 = 9'($urandom % 512);
      sg = ($urandom % 4) != 0;
      send_frame(d9, sg);
      model_rx(d9, sg);
      chk_rx("R4 R5 R6 R7 R8 random");
      if ($urandom % 2 == 1) begin
        reg_read(2'd0, 1'b1, v);
        m_full = 1'b0;
      end
      if ($urandom % 4 == 0) begin
        reg_write(2'd2, 8'h00);
        m_fe = 1'b0; m_ovr = 1'b0;
      end
    end

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule